// File: doc/BRIEF.md
# Burst Boundary Splitting Adapter

This adapter sits between a bus master that only issues incrementing bursts and a memory slave that wraps any burst at a fixed address window. The window size in bytes is the slave's longest burst in beats times its data width in bytes. When a burst stays inside one window, the slave's wrapping can never be triggered, so the adapter passes the burst on as a single command. When a burst would run past the end of its window, the slave would send the later beats back to the start of the window. The adapter prevents this by reissuing the burst as a series of one-beat commands, so each beat is written to the linear address the master intended.

The upstream side has a valid/ready command channel (byte address and beat count) and a valid/ready write data channel. The downstream side has the same two channels, and the data channel adds a flag on the last beat of each issued piece. The upstream command stays pending, with its ready low, until the adapter has moved its final data beat downstream. Addresses are word aligned. The beat count lies between 1 and the slave's maximum burst length.

Top module: `burst_split_adapter`

## Requirements
- R1: With a window of MAX_BURST beats of DATA_W/8 bytes, a burst is treated as fitting when its beat offset inside the window (address bits [log2(DATA_W/8) +: log2(MAX_BURST)]) plus its beat count is at most MAX_BURST. A burst that does not fit is split.
- R2: A fitting burst of more than one beat goes downstream as exactly one command with its original address and count. This includes every burst that starts on a window boundary.
- R3: A burst that does not fit goes downstream as count separate commands of length 1, in increasing order. Piece i carries address start + i*DATA_W/8.
- R4: Write beat i of a command reaches the slave at address start + i*DATA_W/8 and carries the i-th upstream data word. No beat wraps back to a lower address.
- R5: No downstream command with a count above 1 covers addresses in two windows.
- R6: A command with a count of 1 is forwarded unchanged, with the same address and a count of 1, whatever its alignment.
- R7: up_cmd_ready is high only in the cycle in which the last data beat of the pending command is accepted downstream, once per command.
- R8: Write beats pass through (valid, ready and data) only after the command of their piece has been accepted. Each piece passes exactly its count of beats, and dn_wd_last is 1 on the last beat of each piece. A downstream command and a data beat are never offered in the same cycle.
- R9: The first downstream command is valid in the cycle after the adapter, while idle, sees a valid upstream command. Each later piece's command is valid in the cycle after the previous piece's last beat is accepted.
- R10: During reset and on the first cycle after it, dn_cmd_valid, dn_wd_valid, up_cmd_ready and up_wd_ready are low.
- R11: While dn_cmd_valid is high and dn_cmd_ready is low, the downstream command's valid, address and count stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_cmd_valid | input | 1 | Upstream command valid |
| up_cmd_ready | output | 1 | Upstream command consumed (last beat moved) |
| up_cmd_addr | input | ADDR_W | Upstream start byte address |
| up_cmd_len | input | LEN_W | Upstream beat count, 1..MAX_BURST |
| up_wd_valid | input | 1 | Upstream write beat valid |
| up_wd_ready | output | 1 | Upstream write beat accepted |
| up_wd_data | input | DATA_W | Upstream write data |
| dn_cmd_valid | output | 1 | Downstream command valid |
| dn_cmd_ready | input | 1 | Downstream command accepted |
| dn_cmd_addr | output | ADDR_W | Downstream piece start byte address |
| dn_cmd_len | output | LEN_W | Downstream piece beat count |
| dn_wd_valid | output | 1 | Downstream write beat valid |
| dn_wd_ready | input | 1 | Downstream write beat accepted |
| dn_wd_data | output | DATA_W | Downstream write data |
| dn_wd_last | output | 1 | Last beat of the current piece |

## Verification
The first command is due one register stage after an idle adapter sees an upstream command. Each further piece's command is due one cycle after the previous piece's final beat. Data beats and the release of up_cmd_ready are combinational, in the same cycle as the downstream acceptance. The bench drives inputs on the falling edge and samples two nanoseconds later, so each handshake it records is the one that the next rising edge commits. In a directed phase with the slave always ready, it compares the iteration of each command acceptance against the iteration of the stimulus that should cause it. In the random phase, with random readiness, it checks order, addresses, data and the last-beat flags against a transaction list that a bench function computes in advance.

// File: rtl/burst_split_pkg.sv
package burst_split_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    // true when a burst starting at beat_off inside its window ends inside it
    function automatic bit window_fits(int unsigned beat_off, int unsigned beats,
                                       int unsigned max_beats);
        return (beat_off + beats) <= max_beats;
    endfunction

    function automatic bit is_pow2(int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/bsplit_plan.sv
module bsplit_plan
    import burst_split_pkg::*;
#(
    parameter int MAX_BURST = 4,
    parameter int LEN_W     = $clog2(MAX_BURST) + 1,
    parameter int OFF_W     = $clog2(MAX_BURST)
) (
    input  logic [OFF_W-1:0] beat_off,
    input  logic [LEN_W-1:0] beats,
    output logic             split
);
    always_comb begin
        split = !window_fits(32'(beat_off), 32'(beats), MAX_BURST);
    end
endmodule

// File: rtl/bsplit_ctrl.sv
module bsplit_ctrl
    import burst_split_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MAX_BURST = 4,
    parameter int LEN_W     = $clog2(MAX_BURST) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_cmd_valid,
    input  logic [ADDR_W-1:0] up_cmd_addr,
    input  logic [LEN_W-1:0]  up_cmd_len,
    input  logic              split_in,
    input  logic              dn_cmd_ready,
    input  logic              beat_fire,
    output logic              dn_cmd_valid,
    output logic [ADDR_W-1:0] dn_cmd_addr,
    output logic [LEN_W-1:0]  dn_cmd_len,
    output logic              data_phase,
    output logic              piece_last,
    output logic              cmd_done
);
    localparam int BSH = $clog2(DATA_W / 8);

    phase_e            ph_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  total_q;
    logic [LEN_W-1:0]  idx_q;
    logic              split_q;
    logic [LEN_W-1:0]  idx_nxt;
    logic              last_all;

    always_comb begin
        idx_nxt      = idx_q + LEN_W'(1);
        last_all     = (idx_nxt == total_q);
        piece_last   = split_q || last_all;
        data_phase   = (ph_q == PH_DATA);
        dn_cmd_valid = (ph_q == PH_CMD);
        dn_cmd_addr  = base_q + (ADDR_W'(idx_q) << BSH);
        dn_cmd_len   = split_q ? LEN_W'(1) : total_q;
        cmd_done     = data_phase && beat_fire && last_all;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            base_q  <= '0;
            total_q <= '0;
            idx_q   <= '0;
            split_q <= 1'b0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (up_cmd_valid) begin
                        base_q  <= up_cmd_addr;
                        total_q <= up_cmd_len;
                        split_q <= split_in;
                        idx_q   <= '0;
                        ph_q    <= PH_CMD;
                    end
                end
                PH_CMD: begin
                    if (dn_cmd_ready) ph_q <= PH_DATA;
                end
                PH_DATA: begin
                    if (beat_fire) begin
                        idx_q <= idx_nxt;
                        if (last_all)        ph_q <= PH_IDLE;
                        else if (piece_last) ph_q <= PH_CMD;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // R9: an idle adapter offers the first piece one cycle after seeing a command
    a_r9_first_cmd: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_IDLE && up_cmd_valid) |=> dn_cmd_valid);

    // R9: next piece follows the last beat of the previous one
    a_r9_next_piece: assert property (@(posedge clk) disable iff (rst)
        (data_phase && beat_fire && piece_last && !cmd_done) |=> dn_cmd_valid);

    // R6: single-beat commands are forwarded as they came
    a_r6_single_beat: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_IDLE && up_cmd_valid && up_cmd_len == LEN_W'(1)) |=>
        (dn_cmd_len == LEN_W'(1) && dn_cmd_addr == $past(up_cmd_addr)));
endmodule

// File: rtl/bsplit_wdata.sv
module bsplit_wdata #(
    parameter int DATA_W = 32
) (
    input  logic              data_phase,
    input  logic              piece_last,
    input  logic              up_wd_valid,
    input  logic [DATA_W-1:0] up_wd_data,
    input  logic              dn_wd_ready,
    output logic              up_wd_ready,
    output logic              dn_wd_valid,
    output logic [DATA_W-1:0] dn_wd_data,
    output logic              dn_wd_last,
    output logic              beat_fire
);
    always_comb begin
        dn_wd_valid = data_phase && up_wd_valid;
        up_wd_ready = data_phase && dn_wd_ready;
        dn_wd_data  = up_wd_data;
        dn_wd_last  = data_phase && piece_last;
        beat_fire   = dn_wd_valid && dn_wd_ready;
    end
endmodule

// File: rtl/burst_split_adapter.sv
module burst_split_adapter
    import burst_split_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MAX_BURST = 4,
    parameter int LEN_W     = $clog2(MAX_BURST) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_cmd_valid,
    output logic              up_cmd_ready,
    input  logic [ADDR_W-1:0] up_cmd_addr,
    input  logic [LEN_W-1:0]  up_cmd_len,
    input  logic              up_wd_valid,
    output logic              up_wd_ready,
    input  logic [DATA_W-1:0] up_wd_data,
    output logic              dn_cmd_valid,
    input  logic              dn_cmd_ready,
    output logic [ADDR_W-1:0] dn_cmd_addr,
    output logic [LEN_W-1:0]  dn_cmd_len,
    output logic              dn_wd_valid,
    input  logic              dn_wd_ready,
    output logic [DATA_W-1:0] dn_wd_data,
    output logic              dn_wd_last
);
    localparam int BSH   = $clog2(DATA_W / 8);
    localparam int OFF_W = $clog2(MAX_BURST);

    initial begin
        a_params_pow2: assert (is_pow2(MAX_BURST) && MAX_BURST >= 2 &&
                               is_pow2(DATA_W / 8) && DATA_W >= 8);
    end

    logic split;
    logic data_phase;
    logic piece_last;
    logic beat_fire;
    logic cmd_done;

    bsplit_plan #(.MAX_BURST(MAX_BURST), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_plan (
        .beat_off (up_cmd_addr[BSH +: OFF_W]),
        .beats    (up_cmd_len),
        .split    (split)
    );

    bsplit_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .up_cmd_valid (up_cmd_valid),
        .up_cmd_addr  (up_cmd_addr),
        .up_cmd_len   (up_cmd_len),
        .split_in     (split),
        .dn_cmd_ready (dn_cmd_ready),
        .beat_fire    (beat_fire),
        .dn_cmd_valid (dn_cmd_valid),
        .dn_cmd_addr  (dn_cmd_addr),
        .dn_cmd_len   (dn_cmd_len),
        .data_phase   (data_phase),
        .piece_last   (piece_last),
        .cmd_done     (cmd_done)
    );

    bsplit_wdata #(.DATA_W(DATA_W)) u_wdata (
        .data_phase  (data_phase),
        .piece_last  (piece_last),
        .up_wd_valid (up_wd_valid),
        .up_wd_data  (up_wd_data),
        .dn_wd_ready (dn_wd_ready),
        .up_wd_ready (up_wd_ready),
        .dn_wd_valid (dn_wd_valid),
        .dn_wd_data  (dn_wd_data),
        .dn_wd_last  (dn_wd_last),
        .beat_fire   (beat_fire)
    );

    assign up_cmd_ready = cmd_done;

    // R1: upstream count must lie in 1..MAX_BURST
    a_r1_len_legal: assert property (@(posedge clk) disable iff (rst)
        up_cmd_valid |-> (up_cmd_len != '0 && 32'(up_cmd_len) <= MAX_BURST));

    // R5: a multi-beat downstream command stays inside one window
    a_r5_no_straddle: assert property (@(posedge clk) disable iff (rst)
        dn_cmd_valid |-> (32'(dn_cmd_addr[BSH +: OFF_W]) + 32'(dn_cmd_len)) <= MAX_BURST);

    // R7: the upstream command is released only with its final beat
    a_r7_release_on_last: assert property (@(posedge clk) disable iff (rst)
        up_cmd_ready |-> (dn_wd_valid && dn_wd_ready && dn_wd_last));

    // R8: command and data phases never overlap
    a_r8_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(dn_cmd_valid && dn_wd_valid));

    // R10: outputs quiet after a reset cycle
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (!dn_cmd_valid && !dn_wd_valid && !up_cmd_ready && !up_wd_ready));

    // R11: a stalled downstream command holds
    a_r11_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (dn_cmd_valid && !dn_cmd_ready) |=>
        (dn_cmd_valid && $stable(dn_cmd_addr) && $stable(dn_cmd_len)));
endmodule

// File: tb/sim_burst_split_adapter.sv
module sim_burst_split_adapter;
    localparam int AW = 32, DW = 32, MAXB = 4, LW = 3, BY = DW / 8;
    localparam int NT = 260, NDIR = 8;
    localparam int NB = NT * MAXB;

    logic clk = 1'b0, rst = 1'b1;
    logic up_cmd_valid = 0, up_cmd_ready;
    logic [AW-1:0] up_cmd_addr = '0;
    logic [LW-1:0] up_cmd_len = '0;
    logic up_wd_valid = 0, up_wd_ready;
    logic [DW-1:0] up_wd_data = '0;
    logic dn_cmd_valid, dn_cmd_ready = 0;
    logic [AW-1:0] dn_cmd_addr;
    logic [LW-1:0] dn_cmd_len;
    logic dn_wd_valid, dn_wd_ready = 0, dn_wd_last;
    logic [DW-1:0] dn_wd_data;

    always #5 clk = ~clk;

    burst_split_adapter #(.ADDR_W(AW), .DATA_W(DW), .MAX_BURST(MAXB), .LEN_W(LW)) u0 (
        .clk(clk), .rst(rst),
        .up_cmd_valid(up_cmd_valid), .up_cmd_ready(up_cmd_ready),
        .up_cmd_addr(up_cmd_addr), .up_cmd_len(up_cmd_len),
        .up_wd_valid(up_wd_valid), .up_wd_ready(up_wd_ready), .up_wd_data(up_wd_data),
        .dn_cmd_valid(dn_cmd_valid), .dn_cmd_ready(dn_cmd_ready),
        .dn_cmd_addr(dn_cmd_addr), .dn_cmd_len(dn_cmd_len),
        .dn_wd_valid(dn_wd_valid), .dn_wd_ready(dn_wd_ready),
        .dn_wd_data(dn_wd_data), .dn_wd_last(dn_wd_last)
    );

    int n_chk = 0, n_bad = 0;
    int unsigned t_addr [NT];
    int unsigned t_len  [NT];
    int unsigned t_end  [NT];     // beat index after last beat of txn
    int unsigned p_addr [NB];
    int unsigned p_len  [NB];
    int unsigned p_txn  [NB];
    int unsigned e_addr [NB];
    logic [DW-1:0] e_data [NB];
    int np = 0, nb = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit fits(int unsigned a, int unsigned l);
        return (((a / BY) % MAXB) + l) <= MAXB;
    endfunction

    function automatic string tag_of(int unsigned l, bit f);
        if (l == 1) return "R6";
        return f ? "R2" : "R3";
    endfunction

    initial begin
        int unsigned da [NDIR] = '{32'h0, 32'h4, 32'hC, 32'h8, 32'hC, 32'h4, 32'h20, 32'h14};
        int unsigned dl [NDIR] = '{4, 2, 2, 4, 1, 3, 3, 4};
        int ci, di, pi, bi, cyc, pres_cyc, last_beat_cyc, beat_in, first_piece;
        int unsigned cur_addr, cur_len;
        bit directed, prev_stall, pend_first;
        int unsigned prev_addr, prev_len;
        bit cf, bf, uf, uwf;
        void'($urandom(32'd1234));
        // build transaction list and expected streams
        for (int t = 0; t < NT; t++) begin
            if (t < NDIR) begin t_addr[t] = da[t]; t_len[t] = dl[t]; end
            else begin t_addr[t] = ($urandom % 64) * BY; t_len[t] = 1 + $urandom % MAXB; end
            // R1: fit decision from window offset and count
            if (fits(t_addr[t], t_len[t])) begin
                p_addr[np] = t_addr[t]; p_len[np] = t_len[t]; p_txn[np] = t; np++;
            end else begin
                for (int k = 0; k < int'(t_len[t]); k++) begin
                    p_addr[np] = t_addr[t] + k * BY; p_len[np] = 1; p_txn[np] = t; np++;
                end
            end
            for (int k = 0; k < int'(t_len[t]); k++) begin
                e_addr[nb] = t_addr[t] + k * BY; e_data[nb] = $urandom; nb++;
            end
            t_end[t] = nb;
        end

        // reset and R10
        repeat (3) @(negedge clk);
        #2;
        chk(!dn_cmd_valid && !dn_wd_valid && !up_cmd_ready && !up_wd_ready, "R10 during reset",
            {dn_cmd_valid, dn_wd_valid, up_cmd_ready, up_wd_ready}, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #2;
        chk(!dn_cmd_valid && !dn_wd_valid && !up_cmd_ready && !up_wd_ready, "R10 after reset",
            {dn_cmd_valid, dn_wd_valid, up_cmd_ready, up_wd_ready}, 0);

        ci = 0; di = 0; pi = 0; bi = 0; cyc = 0; beat_in = 0;
        cur_addr = 0; cur_len = 0; prev_stall = 0; prev_addr = 0; prev_len = 0;
        pres_cyc = 0; last_beat_cyc = -10; pend_first = 1; first_piece = 0;
        while (ci < NT) begin
            @(negedge clk);
            directed = (ci < NDIR);
            up_cmd_valid = 1'b1;
            up_cmd_addr  = t_addr[ci];
            up_cmd_len   = LW'(t_len[ci]);
            up_wd_valid  = directed ? 1'b1 : (di < nb) && ($urandom % 4 != 0);
            up_wd_data   = (di < nb) ? e_data[di] : '0;
            dn_cmd_ready = directed ? 1'b1 : ($urandom % 4 != 0);
            dn_wd_ready  = directed ? 1'b1 : ($urandom % 4 != 0);
            #2;
            cf  = dn_cmd_valid && dn_cmd_ready;
            bf  = dn_wd_valid && dn_wd_ready;
            uf  = up_cmd_valid && up_cmd_ready;
            uwf = up_wd_valid && up_wd_ready;
            if (prev_stall) begin
                chk(dn_cmd_valid && dn_cmd_addr == prev_addr && dn_cmd_len == LW'(prev_len),
                    "R11 stalled command held", dn_cmd_addr, prev_addr);
            end
            prev_stall = dn_cmd_valid && !dn_cmd_ready;
            prev_addr = dn_cmd_addr; prev_len = dn_cmd_len;
            if (dn_wd_valid)
                chk(!dn_cmd_valid, "R8 command and data exclusive", dn_cmd_valid, 0);
            chk(uwf == bf, "R8 write beat pass-through", uwf, bf);
            if (cf) begin
                if (pi < np) begin
                    chk(dn_cmd_addr == p_addr[pi], tag_of(t_len[p_txn[pi]], fits(t_addr[p_txn[pi]], t_len[p_txn[pi]])),
                        dn_cmd_addr, p_addr[pi]);
                    chk(dn_cmd_len == LW'(p_len[pi]), "R1 piece count", dn_cmd_len, p_len[pi]);
                    if (p_len[pi] > 1)
                        chk(((p_addr[pi] / BY) % MAXB) + 32'(dn_cmd_len) <= MAXB, "R5 no straddle",
                            dn_cmd_addr, p_addr[pi]);
                    if (directed) begin
                        if (pend_first) chk(cyc == pres_cyc + 1, "R9 first command latency", cyc, pres_cyc + 1);
                        else            chk(cyc == last_beat_cyc + 1, "R9 next piece latency", cyc, last_beat_cyc + 1);
                    end
                end else chk(0, "R3 extra downstream command", dn_cmd_addr, 0);
                pend_first = 0;
                cur_addr = dn_cmd_addr; cur_len = dn_cmd_len; beat_in = 0; pi++;
            end
            if (bf) begin
                if (bi < nb) begin
                    chk(cur_addr + beat_in * BY == e_addr[bi], "R4 beat address", cur_addr + beat_in * BY, e_addr[bi]);
                    chk(dn_wd_data == e_data[bi], "R4 beat data", dn_wd_data, e_data[bi]);
                end else chk(0, "R8 extra data beat", bi, nb);
                chk(dn_wd_last == (beat_in + 1 == int'(cur_len)), "R8 last flag", dn_wd_last, beat_in + 1 == int'(cur_len));
                chk(beat_in < int'(cur_len), "R8 beats per piece", beat_in, cur_len);
                beat_in++; bi++; last_beat_cyc = cyc;
            end
            if (uwf) di++;
            if (up_cmd_ready)
                chk(uf && bf && bi == int'(t_end[ci]), "R7 release on final beat", bi, t_end[ci]);
            else if (bf && bi == int'(t_end[ci]))
                chk(0, "R7 missing release", 0, 1);
            cyc++;
            if (uf) begin
                ci++; pend_first = 1; pres_cyc = cyc;
            end
            if (cyc > 150000) begin
                chk(0, "R7 watchdog expired", cyc, 0);
                break;
            end
        end
        up_cmd_valid = 1'b0;
        chk(pi == np, "R3 piece total", pi, np);
        chk(bi == nb, "R4 beat total", bi, nb);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule